// File: doc/BRIEF.md
# Test Access Port Controller with Output-Float Instruction

This block is a boundary-scan test access port controller driven by the test clock. It holds the sixteen-state TAP sequencer, a three-bit instruction path made of a shift stage and an active register, and a one-stage bypass data register. Besides the mandatory bypass instruction it decodes a non-standard public instruction, HI-Z. While HI-Z is the active instruction, the block drives a chip-wide signal that turns off every pad driver. Two-state drivers are included, so a board tester never has to overdrive the chip's outputs.

A power-on reset input pins the sequencer in Test-Logic-Reset, so the scan logic cannot cause bus contention while supplies ramp up. The serial output comes out as a data bit plus a separate enable, and the tri-state pad for it is outside the block. Boundary cells and pad circuitry are also outside the block. In this block every instruction, HI-Z included, places the bypass stage between TDI and TDO.

Top module: `tap_hiz_ctrl`

## Requirements
- R1: While `powerOnRst` is high the sequencer stays in Test-Logic-Reset whatever `tms` does, `tdoEn` and `padDisable` are low, and the active instruction is the all-ones code; after release the sequencer leaves reset only through `tms`.
- R2: On each rising `tck` edge the sequencer follows the standard 16-state TAP transition graph selected by `tms`.
- R3: Five consecutive rising edges with `tms` high bring the sequencer to Test-Logic-Reset from any state.
- R4: The rising edge that enters Test-Logic-Reset sets the active instruction to 3'b111 (bypass), so `padDisable` is low afterwards.
- R5: Capture-IR loads the instruction shift stage with 3'b001. Shift-IR moves it toward bit 0, with TDI entering at bit 2, and TDO presents bit 0.
- R6: The active instruction changes only on the rising edge taken while in Update-IR, or on entry to Test-Logic-Reset. It is unchanged while shifting, in Exit1-IR and in Update-IR itself.
- R7: `padDisable` is high exactly while the active instruction equals 3'b100 (HI-Z), and it holds through data-register scans.
- R8: Every instruction code, 3'b100 included, selects the bypass stage as the data register.
- R9: Capture-DR loads the bypass stage with 0, so the first bit seen on `tdo` in Shift-DR is 0.
- R10: In Shift-DR, TDI is taken on the rising edge and shows on `tdo` after the next falling edge, one stage of delay.
- R11: `tdo` and `tdoEn` change on falling `tck` edges. `tdoEn` is high only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| powerOnRst | input | 1 | Power-on reset, active high, asynchronous |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in, sampled on rising `tck` |
| tdo | output | 1 | Serial test data out, valid when `tdoEn` is high |
| tdoEn | output | 1 | Output enable for the TDO pad |
| padDisable | output | 1 | Forces all device output drivers to high impedance |

## Verification
A state change, a capture or a shift takes effect on the rising edge at which `tms`/`tdi` are sampled. `padDisable` follows on that same edge, at the edge leaving Update-IR or entering Test-Logic-Reset. `tdo` and `tdoEn` are registered on the falling edge after it, half a cycle later. The bench drives inputs one nanosecond after each falling edge. It advances a reference model at the rising edge and compares all outputs one nanosecond after the following falling edge, where every result of that cycle has settled. Power-on reset acts asynchronously, so its effect on `padDisable` is checked at once, with no clock edge in between.

// File: rtl/tap_hiz_pkg.sv
package tap_hiz_pkg;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SHF_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SHF_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tapState_e;

  // strobes from sequencer to datapath, valid for the current tck period
  typedef struct packed {
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic enterReset;
    logic shiftAny;
  } tapStrobe_t;

endpackage

// File: rtl/tap_hiz_fsm.sv
module tap_hiz_fsm
  import tap_hiz_pkg::*;
#(
  parameter int RESET_RUN = 5
) (
  input  logic       tck,
  input  logic       powerOnRst,
  input  logic       tms,
  output tapStrobe_t st
);

  localparam int RUN_W = $clog2(RESET_RUN + 1);

  tapState_e state, nextState;

  always_comb begin
    unique case (state)
      TLR:     nextState = tms ? TLR    : RTI;
      RTI:     nextState = tms ? SEL_DR : RTI;
      SEL_DR:  nextState = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nextState = tms ? EX1_DR : SHF_DR;
      SHF_DR:  nextState = tms ? EX1_DR : SHF_DR;
      EX1_DR:  nextState = tms ? UPD_DR : PAU_DR;
      PAU_DR:  nextState = tms ? EX2_DR : PAU_DR;
      EX2_DR:  nextState = tms ? UPD_DR : SHF_DR;
      UPD_DR:  nextState = tms ? SEL_DR : RTI;
      SEL_IR:  nextState = tms ? TLR    : CAP_IR;
      CAP_IR:  nextState = tms ? EX1_IR : SHF_IR;
      SHF_IR:  nextState = tms ? EX1_IR : SHF_IR;
      EX1_IR:  nextState = tms ? UPD_IR : PAU_IR;
      PAU_IR:  nextState = tms ? EX2_IR : PAU_IR;
      EX2_IR:  nextState = tms ? UPD_IR : SHF_IR;
      UPD_IR:  nextState = tms ? SEL_DR : RTI;
      default: nextState = TLR;
    endcase
  end

  always_ff @(posedge tck or posedge powerOnRst) begin
    if (powerOnRst) state <= TLR;
    else            state <= nextState;
  end

  always_comb begin
    st.captureIr  = (state == CAP_IR);
    st.shiftIr    = (state == SHF_IR);
    st.updateIr   = (state == UPD_IR);
    st.captureDr  = (state == CAP_DR);
    st.shiftDr    = (state == SHF_DR);
    st.enterReset = (nextState == TLR);
    st.shiftAny   = (state == SHF_IR) || (state == SHF_DR);
  end

  // checker: run length of tms-high edges, saturating
  logic [RUN_W-1:0] onesRun;
  always_ff @(posedge tck or posedge powerOnRst) begin
    if (powerOnRst)                              onesRun <= '0;
    else if (!tms)                               onesRun <= '0;
    else if (onesRun < RUN_W'(RESET_RUN))        onesRun <= onesRun + 1'b1;
  end

  a_r3_five_ones_reset: assert property (@(posedge tck) disable iff (powerOnRst)
    (onesRun == RUN_W'(RESET_RUN)) |-> (state == TLR));

  a_r2_shift_dr_holds: assert property (@(posedge tck) disable iff (powerOnRst)
    (state == SHF_DR && !tms) |=> (state == SHF_DR));

  always @(negedge tck) begin
    if (powerOnRst) begin
      a_r1_por_hold: assert (state == TLR);
    end
  end

endmodule

// File: rtl/tap_hiz_datapath.sv
module tap_hiz_datapath
  import tap_hiz_pkg::*;
#(
  parameter int               IR_W        = 3,
  parameter logic [IR_W-1:0]  HIZ_CODE    = 3'b100,
  parameter logic [IR_W-1:0]  CAPTURE_VAL = 3'b001
) (
  input  logic       tck,
  input  logic       powerOnRst,
  input  logic       tdi,
  input  tapStrobe_t st,
  output logic       tdo,
  output logic       tdoEn,
  output logic       padDisable
);

  logic [IR_W-1:0] irShift, irActive;
  logic            bypassBit, tdoQ, tdoEnQ;

  always_ff @(posedge tck or posedge powerOnRst) begin
    if (powerOnRst)        irShift <= '0;
    else if (st.captureIr) irShift <= CAPTURE_VAL;
    else if (st.shiftIr)   irShift <= {tdi, irShift[IR_W-1:1]};
  end

  always_ff @(posedge tck or posedge powerOnRst) begin
    if (powerOnRst)         irActive <= '1;
    else if (st.enterReset) irActive <= '1;
    else if (st.updateIr)   irActive <= irShift;
  end

  // every instruction selects the single bypass stage
  always_ff @(posedge tck or posedge powerOnRst) begin
    if (powerOnRst)        bypassBit <= 1'b0;
    else if (st.captureDr) bypassBit <= 1'b0;
    else if (st.shiftDr)   bypassBit <= tdi;
  end

  always_ff @(negedge tck or posedge powerOnRst) begin
    if (powerOnRst) begin
      tdoQ   <= 1'b0;
      tdoEnQ <= 1'b0;
    end else begin
      tdoQ   <= st.shiftIr ? irShift[0] : bypassBit;
      tdoEnQ <= st.shiftAny;
    end
  end

  assign tdo        = tdoQ;
  assign tdoEn      = tdoEnQ;
  assign padDisable = (irActive == HIZ_CODE);

  a_r4_reset_to_bypass: assert property (@(posedge tck) disable iff (powerOnRst)
    st.enterReset |=> (irActive == '1 && !padDisable));

  a_r6_ir_stable: assert property (@(posedge tck) disable iff (powerOnRst)
    (!st.updateIr && !st.enterReset) |=> $stable(irActive));

  a_r7_hiz_from_update: assert property (@(posedge tck) disable iff (powerOnRst)
    $rose(padDisable) |-> $past(st.updateIr));

  a_r9_capture_zero: assert property (@(posedge tck) disable iff (powerOnRst)
    st.captureDr |=> !bypassBit);

  a_r11_enable_in_shift: assert property (@(posedge tck) disable iff (powerOnRst)
    tdoEn |-> st.shiftAny);

endmodule

// File: rtl/tap_hiz_ctrl.sv
module tap_hiz_ctrl
  import tap_hiz_pkg::*;
#(
  parameter int              IR_W        = 3,
  parameter logic [IR_W-1:0] HIZ_CODE    = 3'b100,
  parameter logic [IR_W-1:0] CAPTURE_VAL = 3'b001,
  parameter int              RESET_RUN   = 5
) (
  input  logic tck,
  input  logic powerOnRst,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdoEn,
  output logic padDisable
);

  tapStrobe_t strobes;

  tap_hiz_fsm #(.RESET_RUN(RESET_RUN)) u_fsm (
    .tck        (tck),
    .powerOnRst (powerOnRst),
    .tms        (tms),
    .st         (strobes)
  );

  tap_hiz_datapath #(
    .IR_W        (IR_W),
    .HIZ_CODE    (HIZ_CODE),
    .CAPTURE_VAL (CAPTURE_VAL)
  ) u_dp (
    .tck        (tck),
    .powerOnRst (powerOnRst),
    .tdi        (tdi),
    .st         (strobes),
    .tdo        (tdo),
    .tdoEn      (tdoEn),
    .padDisable (padDisable)
  );

endmodule

// File: tb/test_tap_hiz_ctrl.sv
`timescale 1ns/1ps
module test_tap_hiz_ctrl;

  logic tck = 1'b0, powerOnRst = 1'b1, tms = 1'b0, tdi = 1'b0;
  logic tdo, tdoEn, padDisable;

  tap_hiz_ctrl i_tap_hiz_ctrl (
    .tck(tck), .powerOnRst(powerOnRst), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdoEn(tdoEn), .padDisable(padDisable)
  );

  always #2 tck = ~tck;  // 250 MHz

  localparam int S_TLR=0, S_RTI=1, S_SDR=2, S_CDR=3, S_SHDR=4, S_E1DR=5, S_PDR=6, S_E2DR=7,
                 S_UDR=8, S_SIR=9, S_CIR=10, S_SHIR=11, S_E1IR=12, S_PIR=13, S_E2IR=14, S_UIR=15;

  int checks = 0, errors = 0;
  int mState = S_TLR;
  logic [2:0] mIr = 3'b111, mIrSh = 3'b000;
  logic mByp = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int nxt(int s, logic t);
    case (s)
      S_TLR:  return t ? S_TLR  : S_RTI;
      S_RTI:  return t ? S_SDR  : S_RTI;
      S_SDR:  return t ? S_SIR  : S_CDR;
      S_CDR:  return t ? S_E1DR : S_SHDR;
      S_SHDR: return t ? S_E1DR : S_SHDR;
      S_E1DR: return t ? S_UDR  : S_PDR;
      S_PDR:  return t ? S_E2DR : S_PDR;
      S_E2DR: return t ? S_UDR  : S_SHDR;
      S_UDR:  return t ? S_SDR  : S_RTI;
      S_SIR:  return t ? S_TLR  : S_CIR;
      S_CIR:  return t ? S_E1IR : S_SHIR;
      S_SHIR: return t ? S_E1IR : S_SHIR;
      S_E1IR: return t ? S_UIR  : S_PIR;
      S_PIR:  return t ? S_E2IR : S_PIR;
      S_E2IR: return t ? S_UIR  : S_SHIR;
      default: return t ? S_SDR : S_RTI;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one tck cycle with model update and per-cycle comparison
  task automatic step(input logic t, input logic d);
    logic expEn, expTdo;
    tms = t; tdi = d;
    @(posedge tck);
    case (mState)
      S_CIR:  mIrSh = 3'b001;
      S_SHIR: mIrSh = {d, mIrSh[2:1]};
      S_UIR:  mIr = mIrSh;
      S_CDR:  mByp = 1'b0;
      S_SHDR: mByp = d;
      default: ;
    endcase
    mState = nxt(mState, t);
    if (mState == S_TLR) mIr = 3'b111;
    @(negedge tck); #1;
    expEn = (mState == S_SHIR) || (mState == S_SHDR);
    check(tdoEn == expEn, "R11/R2 tdoEn", tdoEn, expEn);
    check(padDisable == (mIr == 3'b100), "R7 padDisable", padDisable, mIr == 3'b100);
    if (expEn) begin
      expTdo = (mState == S_SHIR) ? mIrSh[0] : mByp;
      check(tdo == expTdo, (mState == S_SHIR) ? "R5 ir shift tdo" : "R10 bypass tdo", tdo, expTdo);
    end
  endtask

  task automatic porStep(input logic t, input logic d);
    powerOnRst = 1'b1; tms = t; tdi = d;
    @(posedge tck); @(negedge tck); #1;
    mState = S_TLR; mIr = 3'b111; mByp = 1'b0; mIrSh = 3'b000;
    check(tdoEn == 1'b0, "R1 tdoEn under reset", tdoEn, 0);
    check(padDisable == 1'b0, "R1 padDisable under reset", padDisable, 0);
  endtask

  // from Test-Logic-Reset: reach Shift-IR and confirm the captured LSB
  task automatic probeFromReset(input string req);
    step(0, 0); step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    check(tdoEn == 1'b1 && tdo == 1'b1, req, {tdoEn, tdo}, 2'b11);
  endtask

  task automatic loadIr(input logic [2:0] code);
    repeat (5) step(1, 0);
    check(padDisable == 1'b0, "R4 bypass after reset", padDisable, 0);
    step(0, 0); step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    step(0, code[0]); step(0, code[1]); step(1, code[2]);
    check(padDisable == 1'b0, "R6 no update in Exit1-IR", padDisable, 0);
    step(1, 0);
    check(padDisable == 1'b0, "R6 no update in Update-IR", padDisable, 0);
    step(0, 0);
    check(padDisable == (code == 3'b100), "R7 decode after update", padDisable, code == 3'b100);
  endtask

  task automatic drScan(input logic [7:0] pat, input logic [2:0] code);
    step(1, 0); step(0, 0); step(0, 0);
    check(tdoEn == 1'b1 && tdo == 1'b0, "R9 first DR bit zero", {tdoEn, tdo}, 2'b10);
    for (int i = 0; i < 8; i++) begin
      step(i == 7, pat[i]);
      if (i < 7) check(tdo == pat[i], "R8 bypass selected", tdo, pat[i]);
    end
    step(1, 0); step(0, 0);
    check(padDisable == (code == 3'b100), "R7 held over DR scan", padDisable, code == 3'b100);
  endtask

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge tck);
    checks++; errors++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    // R1: tms sequence that would load HI-Z is ignored under reset
    porStep(0, 0); porStep(1, 0); porStep(1, 0); porStep(0, 0); porStep(0, 0);
    porStep(0, 0); porStep(0, 0); porStep(1, 1); porStep(1, 0); porStep(0, 0);
    powerOnRst = 1'b0;
    check(padDisable == 1'b0, "R1 no instruction loaded", padDisable, 0);
    probeFromReset("R1 sequencer released from reset state");

    // all instruction codes: decode and bypass path
    for (int c = 0; c < 8; c++) begin
      loadIr(3'(c));
      drScan(8'(c * 37 + 8'h5A), 3'(c));
      drScan(8'(~(c * 19)), 3'(c));
    end

    // R3: from every state, five tms-high edges reach reset
    for (int s = 0; s < 16; s++) begin
      int guard = 0;
      loadIr(3'b100);
      while (mState != s && guard < 2000) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[0], lfsr[3]);
        guard++;
      end
      check(mState == s, "R2 state reachable", mState, s);
      repeat (5) step(1, lfsr[5]);
      check(padDisable == 1'b0, "R4 HI-Z cleared by reset", padDisable, 0);
      probeFromReset("R3 five ones reach reset");
    end

    // random walk for R2/R5/R10/R11
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[1] & (lfsr[4] | lfsr[7]), lfsr[2]);
    end

    // R1: asynchronous reset mid-run clears HI-Z
    loadIr(3'b100);
    #0.5 powerOnRst = 1'b1;
    #0.5;
    check(padDisable == 1'b0, "R1 async reset clears HI-Z", padDisable, 0);
    porStep(0, 0); porStep(1, 1);
    powerOnRst = 1'b0;
    probeFromReset("R1 reset after mid-run assertion");

    finishRun();
  end

endmodule